// File: doc/BRIEF.md
# Blit address generator

This block walks a rectangle of pixels for a bit-block transfer and emits one address triple per pixel step: a destination byte address, a source byte address and a pattern byte address. A pulse on `start` loads the operation settings (three base addresses, three line pitches, the two pixel counts, the two direction bits and four wrap codes) into internal registers. The block then presents the triple for pixel (0,0), followed by the rest of the first line, then the next line, until the whole rectangle has been covered. Each pixel is one byte, so one step along X moves each address by one byte.

The source and pattern addresses can be confined to small tiles. Each of these two surfaces has its own X wrap code and its own Y wrap code. Under X wrap, only the low bits of the address advance within a line. Under Y wrap, the line index restarts after a set number of lines. The destination never wraps. The consumer takes triples through a valid/ready handshake. `busy` covers the whole operation, and `done` pulses once after the last triple has been taken.

Top module: `blit_addr_gen`

## Requirements
- R1: While reset is held and directly after it, `busy`, `out_valid` and `done` are 0.
- R2: A `start` pulse seen while idle raises `busy` and `out_valid` on the next cycle. The first triple presented equals the destination, source and pattern base addresses sampled with that pulse.
- R3: An operation presents (x_count+1)*(y_count+1) triples. X is the inner loop and lines are the outer loop. Counts of zero give a single triple.
- R4: With `x_dir`=0 each X step adds 1 to an address, and with `x_dir`=1 each X step subtracts 1. With `y_dir`=0 each new line adds that surface's 12-bit pitch to the line start, and with `y_dir`=1 it subtracts the pitch. The settings apply to all three surfaces.
- R5: X wrap codes 2, 3, 4, 5 and 6 select tiles of 4, 8, 16, 32 and 64 bytes, so k = code low bits advance. Under X wrap the address is (line_start with its low k bits kept from the line start) with its low k bits replaced by (line_start + step) mod 2^k, where step is the signed X offset; the bits above stay fixed.
- R6: Y wrap codes 0, 1, 2 and 3 select 1, 2, 4 and 8 lines. Under Y wrap the line start is base ± (line mod lines)*pitch.
- R7: X wrap codes 0, 1 and 7 and Y wrap codes 4, 5, 6 and 7 mean no wrap on that axis.
- R8: The destination address never wraps. Its line start is always base ± line*pitch.
- R9: While `out_valid` is 1 and `out_ready` is 0, all three addresses hold their values and `out_valid` stays 1.
- R10: `done` is 1 for exactly one cycle, the cycle after the last triple is accepted. In that same cycle `busy` and `out_valid` are 0.
- R11: A `start` pulse while busy has no effect. The running sequence and its addresses continue unchanged, even when the input settings change.
- R12: Addresses are 22 bits and all arithmetic wraps modulo 2^22.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (taken only when idle) |
| dst_base | input | 22 | Destination start address |
| src_base | input | 22 | Source start address |
| pat_base | input | 22 | Pattern start address |
| dst_pitch | input | 12 | Destination line pitch in bytes |
| src_pitch | input | 12 | Source line pitch in bytes |
| pat_pitch | input | 12 | Pattern line pitch in bytes |
| x_count | input | 12 | Pixels per line minus one |
| y_count | input | 12 | Lines minus one |
| x_dir | input | 1 | 1 = step backwards along X |
| y_dir | input | 1 | 1 = step backwards along Y |
| src_xwrap | input | 3 | Source X wrap code |
| src_ywrap | input | 3 | Source Y wrap code |
| pat_xwrap | input | 3 | Pattern X wrap code |
| pat_ywrap | input | 3 | Pattern Y wrap code |
| out_valid | output | 1 | Address triple available |
| out_ready | input | 1 | Consumer takes the triple |
| out_dst | output | 22 | Destination byte address |
| out_src | output | 22 | Source byte address |
| out_pat | output | 22 | Pattern byte address |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse after the final triple |

## Verification
The assertions assume that `start` and `out_ready` are synchronous to `clk` and that reset is held low from time zero. They also assume the settings inputs matter only in the cycle `start` is accepted, so the checks compare against the sampled value of `dst_base` and not its live value. The stimulus changes every input half a cycle away from the active edge. It holds `out_ready` low at random for stretches, but a stall never lasts forever. It also pulses `start` with altered base values in the middle of a run, which tests that the settings are taken only at the accepting edge.

// File: rtl/blit_pkg.sv
package blit_pkg;

   localparam int WRAP_CODE_W = 3;
   localparam int TILE_MASK_W = 7;

   typedef struct packed {
      logic                   on;
      logic [TILE_MASK_W-1:0] mask;
   } xwrap_t;

   typedef struct packed {
      logic       on;
      logic [2:0] last;
   } ywrap_t;

   // X tile: codes 2..6 give 4..64 bytes, everything else runs free
   function automatic xwrap_t decode_xwrap(input logic [WRAP_CODE_W-1:0] code);
      xwrap_t r;
      r.on   = (code >= 3'd2) && (code <= 3'd6);
      r.mask = r.on ? TILE_MASK_W'((8'd1 << code) - 8'd1) : '1;
      return r;
   endfunction

   // Y tile: codes 0..3 give 1..8 lines, everything else runs free
   function automatic ywrap_t decode_ywrap(input logic [WRAP_CODE_W-1:0] code);
      ywrap_t r;
      r.on   = (code <= 3'd3);
      r.last = r.on ? 3'((4'd1 << code[1:0]) - 4'd1) : 3'd0;
      return r;
   endfunction

endpackage

// File: rtl/blit_step_ctl.sv
module blit_step_ctl #(
   parameter int CW = 12
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          out_ready,
   input  logic [CW-1:0] x_count,
   input  logic [CW-1:0] y_count,
   output logic          busy,
   output logic          done,
   output logic          load,
   output logic          px_step,
   output logic          ln_step
);

   logic [CW-1:0] xc_q, yc_q, x_idx, y_idx;
   logic          fire, eol, last;

   assign load    = start && !busy;
   assign fire    = busy && out_ready;
   assign eol     = (x_idx == xc_q);
   assign last    = eol && (y_idx == yc_q);
   assign px_step = fire && !eol;
   assign ln_step = fire && eol && !last;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         done  <= 1'b0;
         x_idx <= '0;
         y_idx <= '0;
         xc_q  <= '0;
         yc_q  <= '0;
      end else begin
         done <= fire && last;
         if (load) begin
            busy  <= 1'b1;
            x_idx <= '0;
            y_idx <= '0;
            xc_q  <= x_count;
            yc_q  <= y_count;
         end else if (fire) begin
            if (last) begin
               busy <= 1'b0;
            end else if (eol) begin
               x_idx <= '0;
               y_idx <= y_idx + 1'b1;
            end else begin
               x_idx <= x_idx + 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/blit_surf_walk.sv
module blit_surf_walk
   import blit_pkg::*;
#(
   parameter int AW      = 22,
   parameter int PW      = 12,
   parameter bit WRAP_EN = 1'b1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   load,
   input  logic                   px_step,
   input  logic                   ln_step,
   input  logic [AW-1:0]          base,
   input  logic [PW-1:0]          pitch,
   input  logic                   x_dir,
   input  logic                   y_dir,
   input  logic [WRAP_CODE_W-1:0] xwrap,
   input  logic [WRAP_CODE_W-1:0] ywrap,
   output logic [AW-1:0]          addr
);

   localparam int PAD = AW - PW;

   logic [AW-1:0] base_q, pitch_q, line_q, cur_q, xmask_q;
   logic          xd_q, yd_q;
   logic [AW-1:0] xmask_d, px_next, ln_next, inc;
   logic          ywon_d;
   logic [2:0]    ylast_d;

   generate
      if (WRAP_EN) begin : g_wrap
         xwrap_t xw;
         ywrap_t yw;
         logic       ywon_q;
         logic [2:0] ylast_q, ycnt_q;
         logic       tile_end;

         assign xw      = decode_xwrap(xwrap);
         assign yw      = decode_ywrap(ywrap);
         assign xmask_d = xw.on ? {{(AW-TILE_MASK_W){1'b0}}, xw.mask} : '1;
         assign ywon_d  = yw.on;
         assign ylast_d = yw.last;
         assign tile_end = ywon_q && (ycnt_q == ylast_q);

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               ywon_q  <= 1'b0;
               ylast_q <= '0;
               ycnt_q  <= '0;
            end else if (load) begin
               ywon_q  <= ywon_d;
               ylast_q <= ylast_d;
               ycnt_q  <= '0;
            end else if (ln_step) begin
               ycnt_q <= tile_end ? 3'd0 : ycnt_q + 3'd1;
            end
         end

         always_comb begin
            if (tile_end)  ln_next = base_q;
            else if (yd_q) ln_next = line_q - pitch_q;
            else           ln_next = line_q + pitch_q;
         end
      end else begin : g_free
         assign xmask_d = '1;
         assign ywon_d  = 1'b0;
         assign ylast_d = 3'd0;
         always_comb begin
            if (yd_q) ln_next = line_q - pitch_q;
            else      ln_next = line_q + pitch_q;
         end
      end
   endgenerate

   assign inc     = xd_q ? cur_q - 1'b1 : cur_q + 1'b1;
   assign px_next = (cur_q & ~xmask_q) | (inc & xmask_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         base_q  <= '0;
         pitch_q <= '0;
         line_q  <= '0;
         cur_q   <= '0;
         xmask_q <= '1;
         xd_q    <= 1'b0;
         yd_q    <= 1'b0;
      end else if (load) begin
         base_q  <= base;
         pitch_q <= {{PAD{1'b0}}, pitch};
         line_q  <= base;
         cur_q   <= base;
         xmask_q <= xmask_d;
         xd_q    <= x_dir;
         yd_q    <= y_dir;
      end else if (ln_step) begin
         line_q <= ln_next;
         cur_q  <= ln_next;
      end else if (px_step) begin
         cur_q <= px_next;
      end
   end

   assign addr = cur_q;

endmodule

// File: rtl/blit_addr_gen.sv
module blit_addr_gen
   import blit_pkg::*;
#(
   parameter int AW = 22,
   parameter int PW = 12,
   parameter int CW = 12
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   start,
   input  logic [AW-1:0]          dst_base,
   input  logic [AW-1:0]          src_base,
   input  logic [AW-1:0]          pat_base,
   input  logic [PW-1:0]          dst_pitch,
   input  logic [PW-1:0]          src_pitch,
   input  logic [PW-1:0]          pat_pitch,
   input  logic [CW-1:0]          x_count,
   input  logic [CW-1:0]          y_count,
   input  logic                   x_dir,
   input  logic                   y_dir,
   input  logic [WRAP_CODE_W-1:0] src_xwrap,
   input  logic [WRAP_CODE_W-1:0] src_ywrap,
   input  logic [WRAP_CODE_W-1:0] pat_xwrap,
   input  logic [WRAP_CODE_W-1:0] pat_ywrap,
   output logic                   out_valid,
   input  logic                   out_ready,
   output logic [AW-1:0]          out_dst,
   output logic [AW-1:0]          out_src,
   output logic [AW-1:0]          out_pat,
   output logic                   busy,
   output logic                   done
);

   generate
      if (AW <= PW) begin : g_bad_aw
         $error("blit_addr_gen: AW must exceed PW");
      end
      if (AW <= TILE_MASK_W) begin : g_bad_tile
         $error("blit_addr_gen: AW too small for largest tile");
      end
      if (CW < 1) begin : g_bad_cw
         $error("blit_addr_gen: CW must be positive");
      end
   endgenerate

   localparam int NSURF = 3;
   localparam bit [NSURF-1:0] WRAPS = 3'b110;   // {pattern, source, destination}

   logic load, px_step, ln_step;

   logic [AW-1:0]          s_base  [NSURF];
   logic [PW-1:0]          s_pitch [NSURF];
   logic [WRAP_CODE_W-1:0] s_xw    [NSURF];
   logic [WRAP_CODE_W-1:0] s_yw    [NSURF];
   logic [AW-1:0]          s_addr  [NSURF];

   assign s_base[0]  = dst_base;
   assign s_base[1]  = src_base;
   assign s_base[2]  = pat_base;
   assign s_pitch[0] = dst_pitch;
   assign s_pitch[1] = src_pitch;
   assign s_pitch[2] = pat_pitch;
   assign s_xw[0]    = 3'd7;
   assign s_xw[1]    = src_xwrap;
   assign s_xw[2]    = pat_xwrap;
   assign s_yw[0]    = 3'd7;
   assign s_yw[1]    = src_ywrap;
   assign s_yw[2]    = pat_ywrap;

   blit_step_ctl #(.CW(CW)) u_ctl (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .out_ready (out_ready),
      .x_count   (x_count),
      .y_count   (y_count),
      .busy      (busy),
      .done      (done),
      .load      (load),
      .px_step   (px_step),
      .ln_step   (ln_step)
   );

   generate
      for (genvar s = 0; s < NSURF; s++) begin : g_surf
         blit_surf_walk #(.AW(AW), .PW(PW), .WRAP_EN(WRAPS[s])) u_walk (
            .clk     (clk),
            .rst_n   (rst_n),
            .load    (load),
            .px_step (px_step),
            .ln_step (ln_step),
            .base    (s_base[s]),
            .pitch   (s_pitch[s]),
            .x_dir   (x_dir),
            .y_dir   (y_dir),
            .xwrap   (s_xw[s]),
            .ywrap   (s_yw[s]),
            .addr    (s_addr[s])
         );
      end
   endgenerate

   assign out_valid = busy;
   assign out_dst   = s_addr[0];
   assign out_src   = s_addr[1];
   assign out_pat   = s_addr[2];

endmodule

// File: rtl/blit_addr_gen_chk.sv
module blit_addr_gen_chk #(
   parameter int AW = 22
) (
   input logic          clk,
   input logic          rst_n,
   input logic          start,
   input logic [AW-1:0] dst_base,
   input logic          out_valid,
   input logic          out_ready,
   input logic [AW-1:0] out_dst,
   input logic [AW-1:0] out_src,
   input logic [AW-1:0] out_pat,
   input logic          busy,
   input logic          done
);

   assert_start_loads_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> (busy && out_valid && out_dst == $past(dst_base)));

   assert_stall_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_dst)
                                     && $stable(out_src) && $stable(out_pat)));

   assert_done_after_accept_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && !out_valid && $past(out_valid && out_ready)));

   assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_end_signals_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done);

   assert_busy_start_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start && !out_ready) |=> (busy && $stable(out_dst)));

endmodule

bind blit_addr_gen blit_addr_gen_chk #(.AW(AW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start     (start),
   .dst_base  (dst_base),
   .out_valid (out_valid),
   .out_ready (out_ready),
   .out_dst   (out_dst),
   .out_src   (out_src),
   .out_pat   (out_pat),
   .busy      (busy),
   .done      (done)
);

// File: tb/test_blit_addr_gen.sv
module test_blit_addr_gen;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [21:0] dst_base = '0, src_base = '0, pat_base = '0;
   logic [11:0] dst_pitch = '0, src_pitch = '0, pat_pitch = '0;
   logic [11:0] x_count = '0, y_count = '0;
   logic        x_dir = 1'b0, y_dir = 1'b0;
   logic [2:0]  src_xwrap = 3'd7, src_ywrap = 3'd7, pat_xwrap = 3'd7, pat_ywrap = 3'd7;
   logic        out_ready = 1'b0;
   logic        out_valid, busy, done;
   logic [21:0] out_dst, out_src, out_pat;

   int total = 0;
   int bad   = 0;

   // settings the model uses for the current operation
   logic [21:0] c_db, c_sb, c_pb;
   logic [11:0] c_dp, c_sp, c_pp, c_xc, c_yc;
   bit          c_xd, c_yd;
   logic [2:0]  c_sxw, c_syw, c_pxw, c_pyw;

   always #10ns clk = ~clk;

   blit_addr_gen i_blit_addr_gen (
      .clk(clk), .rst_n(rst_n), .start(start),
      .dst_base(dst_base), .src_base(src_base), .pat_base(pat_base),
      .dst_pitch(dst_pitch), .src_pitch(src_pitch), .pat_pitch(pat_pitch),
      .x_count(x_count), .y_count(y_count), .x_dir(x_dir), .y_dir(y_dir),
      .src_xwrap(src_xwrap), .src_ywrap(src_ywrap),
      .pat_xwrap(pat_xwrap), .pat_ywrap(pat_ywrap),
      .out_valid(out_valid), .out_ready(out_ready),
      .out_dst(out_dst), .out_src(out_src), .out_pat(out_pat),
      .busy(busy), .done(done)
   );

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic longint expa(input longint base, input longint pitch, input bit xd,
                                   input bit yd, input int xw, input int yw, input bit wr,
                                   input int i, input int j);
      longint msk = 64'h3FFFFF;
      longint ls, a, m;
      int xk = 0;
      int yn = 0;
      int jj;
      if (wr) begin
         if (xw >= 2 && xw <= 6) xk = xw;
         if (yw <= 3) yn = 1 << yw;
      end
      jj = (yn != 0) ? j % yn : j;
      ls = yd ? base - longint'(jj) * pitch : base + longint'(jj) * pitch;
      ls = ls & msk;
      a  = xd ? ls - i : ls + i;
      if (xk != 0) begin
         m = (longint'(1) << xk) - 1;
         a = (ls & ~m) | (a & m);
      end
      return a & msk;
   endfunction

   task automatic apply_cfg();
      dst_base = c_db;  src_base = c_sb;  pat_base = c_pb;
      dst_pitch = c_dp; src_pitch = c_sp; pat_pitch = c_pp;
      x_count = c_xc;   y_count = c_yc;   x_dir = c_xd; y_dir = c_yd;
      src_xwrap = c_sxw; src_ywrap = c_syw; pat_xwrap = c_pxw; pat_ywrap = c_pyw;
   endtask

   // rdy_mode 0: always ready, 1: random stalls; poke: start pulses while busy
   task automatic run_op(input string tag, input int rdy_mode, input bit poke);
      int i = 0;
      int j = 0;
      int n = 0;
      int npx = (int'(c_xc) + 1) * (int'(c_yc) + 1);
      longint ed, es, ep;
      bit r;
      bit ok;
      @(negedge clk);
      apply_cfg();
      out_ready = 1'b0;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(busy && out_valid && !done, {tag, " R2 busy after start"}, {busy, out_valid, done}, 3'b110);
      while (n < npx) begin
         ed = expa(c_db, c_dp, c_xd, c_yd, 7, 7, 1'b0, i, j);
         es = expa(c_sb, c_sp, c_xd, c_yd, c_sxw, c_syw, 1'b1, i, j);
         ep = expa(c_pb, c_pp, c_xd, c_yd, c_pxw, c_pyw, 1'b1, i, j);
         ok = out_valid && busy && out_dst == ed[21:0] && out_src == es[21:0] && out_pat == ep[21:0];
         if (!ok)
            $display("  %s pixel (%0d,%0d) dst=%0h/%0h src=%0h/%0h", tag, i, j,
                     out_dst, ed, out_src, es);
         chk(ok, {tag, " R3 R4 R5 R6 R8 R9 R12 pattern address"}, longint'(out_pat), ep);
         r = (rdy_mode == 0) ? 1'b1 : (($urandom % 3) != 0);
         out_ready = r;
         if (poke && (($urandom % 4) == 0)) begin
            start = 1'b1;                       // R11: must be ignored
            dst_base = ~c_db;
            x_count = 12'd0;
            x_dir = ~c_xd;
         end
         @(negedge clk);
         start = 1'b0;
         if (r) begin
            n++;
            if (i == int'(c_xc)) begin i = 0; j++; end
            else i++;
            if (n == npx)
               chk(done && !busy && !out_valid, {tag, " R10 done after last"},
                   {done, busy, out_valid}, 3'b100);
            else
               chk(!done, {tag, " R10 no early done"}, done, 0);
         end
      end
      out_ready = 1'b0;
      @(negedge clk);
      chk(!done && !busy, {tag, " R10 done lasts one cycle"}, {done, busy}, 2'b00);
   endtask

   task automatic defaults();
      c_db = 22'h001000; c_sb = 22'h002000; c_pb = 22'h003000;
      c_dp = 12'd64; c_sp = 12'd32; c_pp = 12'd16;
      c_xc = 12'd3;  c_yc = 12'd2;  c_xd = 1'b0; c_yd = 1'b0;
      c_sxw = 3'd7; c_syw = 3'd7; c_pxw = 3'd7; c_pyw = 3'd7;
   endtask

   initial begin
      #3000000ns;
      chk(1'b0, "watchdog expired", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      chk(!busy && !out_valid && !done, "R1 idle in reset", {busy, out_valid, done}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!busy && !out_valid && !done, "R1 idle after reset", {busy, out_valid, done}, 0);

      // plain forward walk
      defaults();
      run_op("R2 forward", 0, 1'b0);

      // backward in both axes, random stalls
      defaults();
      c_xd = 1'b1; c_yd = 1'b1; c_xc = 12'd5; c_yc = 12'd4;
      run_op("R4 backward", 1, 1'b0);

      // X wrap tiles, unaligned bases
      defaults();
      c_pb = 22'h003006; c_pxw = 3'd2; c_xc = 12'd9;
      c_sb = 22'h00200D; c_sxw = 3'd3; c_yc = 12'd1;
      run_op("R5 xwrap fwd", 1, 1'b0);
      c_xd = 1'b1; c_pxw = 3'd6; c_sxw = 3'd4; c_pb = 22'h003041; c_xc = 12'd40;
      run_op("R5 xwrap back", 0, 1'b0);

      // Y wrap tiles
      defaults();
      c_pyw = 3'd0; c_syw = 3'd2; c_yc = 12'd9; c_xc = 12'd2;
      run_op("R6 ywrap", 1, 1'b0);
      c_pyw = 3'd3; c_syw = 3'd1; c_yd = 1'b1; c_pxw = 3'd2; c_sxw = 3'd5;
      run_op("R6 ywrap back combined", 1, 1'b0);

      // reserved codes behave as free running
      defaults();
      c_pxw = 3'd0; c_sxw = 3'd1; c_pyw = 3'd5; c_syw = 3'd4; c_xc = 12'd7; c_yc = 12'd3;
      run_op("R7 reserved codes", 1, 1'b0);
      c_pyw = 3'd6; c_syw = 3'd7;
      run_op("R7 reserved codes b", 0, 1'b0);

      // 22-bit wraparound at both ends
      defaults();
      c_db = 22'h3FFFFE; c_dp = 12'hFFF; c_xc = 12'd4; c_yc = 12'd2;
      c_sb = 22'h000001; c_xd = 1'b1; c_yd = 1'b1; c_sp = 12'd100;
      run_op("R12 modular", 1, 1'b0);

      // single pixel
      defaults();
      c_xc = 12'd0; c_yc = 12'd0;
      run_op("R3 single", 0, 1'b0);

      // start pulses during an operation
      defaults();
      c_xc = 12'd6; c_yc = 12'd5; c_pxw = 3'd2; c_syw = 3'd1;
      run_op("R11 start while busy", 1, 1'b1);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule